// File: doc/BRIEF.md
# Address-Matched Lane Forcing Injector

This block watches a decoded memory command stream. It looks for one programmed command kind at one programmed address. The address compare covers a chip-select field, which is held against a fixed parameter value because that field never changes on the intended platform.

When a command hits and injection is currently allowed, the block claims the data burst that follows. On every even-numbered beat of that burst it asserts a force-enable on each lane selected by a mask, and it drives those lanes to a single programmed level. It has no input carrying the lane's present level. It therefore cannot flip a lane: a lane that already sits at the forced level suffers no real error, yet the attempt is still counted.

Injection is gated by an arm enable and, optionally, by a periodic on/off window built from two programmed lengths. A saturating success counter records every accepted forcing attempt.

The command port and the beat strobe are observe-only, valid-qualified inputs with no ready. The block is a monitor on a bus that it may not stall, so it never applies back-pressure. Every valid beat or command is taken in the cycle it is presented. Configuration pins are plain levels.

Top module: `mem_err_inject`

## Requirements
- R1: `cfg_mode` bit 0 enables matching on read commands (`cmd_is_write`=0) and bit 1 enables matching on write commands (`cmd_is_write`=1). The value 3 matches both kinds and the value 0 matches neither.
- R2: A hit requires `cmd_addr` to equal `cfg_addr` in every bit and `cmd_chip` to equal the parameter `CHIP_ID`. Any differing bit makes the command ignored.
- R3: During a forced beat, `force_en` equals `cfg_mask`. Each enabled lane's `force_val` bit equals `cfg_level`, and every `force_val` bit whose `force_en` bit is 0 is 0. The outputs depend on no lane state.
- R4: After an accepted hit, the next `beat_valid` cycles form a burst of 8 beats (`cmd_bl8`=1) or 4 beats (`cmd_bl8`=0), numbered from 0. Forcing is asserted, in the same cycle as `beat_valid`, only on beats 0, 2, 4 and 6. Odd beats and beats outside a claimed burst show `force_en`=0.
- R5: Each accepted hit increments `success_cnt` by exactly one. The new value is visible in the cycle after the command was presented.
- R6: While `cfg_arm` is 0, hits are ignored: there is no forcing and no count change.
- R7: With `cfg_periodic`=1, counting from the first cycle j=0 in which `cfg_arm` is 1, a hit is accepted only when (j mod (`cfg_on_len`+`cfg_off_len`)) < `cfg_on_len`. With `cfg_periodic`=0 the window is simply `cfg_arm`.
- R8: A hit that arrives while a burst is still claimed is ignored. The running burst continues with its own beat numbering.
- R9: `success_cnt` is `CNT_W` bits wide (default 32) and holds at its all-ones value instead of wrapping.
- R10: `cnt_clr` clears `success_cnt` to 0 on the next edge and takes priority over a simultaneous increment. It does not affect forcing.
- R11: After reset, `success_cnt` is 0, no burst is claimed and `force_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_is_write | input | 1 | 1 = write, 0 = read |
| cmd_chip | input | CHIP_W | Chip-select field of the command |
| cmd_addr | input | ADDR_W | Command address |
| cmd_bl8 | input | 1 | Burst length of the command: 1 = 8 beats, 0 = 4 beats |
| beat_valid | input | 1 | Data beat strobe |
| cfg_addr | input | ADDR_W | Address to match |
| cfg_mode | input | 2 | Command kind select (R1) |
| cfg_mask | input | LANES | Lanes to force |
| cfg_level | input | 1 | Level forced onto the selected lanes |
| cfg_arm | input | 1 | Injection arm enable |
| cfg_periodic | input | 1 | Enables the on/off duty window |
| cfg_on_len | input | TMR_W | Cycles per open phase |
| cfg_off_len | input | TMR_W | Cycles per closed phase |
| cnt_clr | input | 1 | Synchronous counter clear |
| force_en | output | LANES | Per-lane force enable |
| force_val | output | LANES | Per-lane forced level |
| success_cnt | output | CNT_W | Saturating count of forcing attempts |

## Verification
The force outputs are combinational from the claimed-burst state and `beat_valid`. The bench therefore raises each beat at a falling edge and samples `force_en` and `force_val` one time unit later, within that same cycle. A command presented between two falling edges changes `success_cnt` at the rising edge between them, so the count is read at the next falling edge. The periodic window is swept over start offsets 0 to 11 after arming. For each offset the expected acceptance is computed as the offset modulo the period compared against the open length. The mode, lane, level and burst-length sweeps each predict the expected outputs beat by beat from the beat index.

// File: rtl/mei_pkg.sv
package mei_pkg;
  typedef enum logic {
    BURST_IDLE,
    BURST_CLAIMED
  } burst_state_t;

  localparam int MODE_RD_BIT = 0;
  localparam int MODE_WR_BIT = 1;
  localparam int MAX_BURST   = 8;
  localparam int BEAT_W      = $clog2(MAX_BURST);
endpackage

// File: rtl/cmd_match.sv
module cmd_match #(
  parameter int ADDR_W = 16,
  parameter int CHIP_W = 2,
  parameter logic [CHIP_W-1:0] CHIP_ID = '0
) (
  input  logic              cmd_valid_i,
  input  logic              cmd_is_write_i,
  input  logic [CHIP_W-1:0] cmd_chip_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [1:0]        cfg_mode_i,
  output logic              hit_o
);
  import mei_pkg::*;

  logic addr_eq;
  logic chip_eq;
  logic kind_ok;

  always_comb begin
    addr_eq = (cmd_addr_i == cfg_addr_i);
    chip_eq = (cmd_chip_i == CHIP_ID);
    kind_ok = cmd_is_write_i ? cfg_mode_i[MODE_WR_BIT] : cfg_mode_i[MODE_RD_BIT];
    hit_o   = cmd_valid_i && addr_eq && chip_eq && kind_ok;
  end
endmodule

// File: rtl/duty_timer.sv
module duty_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             periodic_i,
  input  logic [TMR_W-1:0] on_len_i,
  input  logic [TMR_W-1:0] off_len_i,
  output logic             win_o
);
  localparam int EXT_W = TMR_W + 1;

  logic [TMR_W-1:0] tcnt_q;
  logic             phase_on_q;
  logic [EXT_W-1:0] tcnt_next_ext;
  logic             phase_end;

  always_comb begin
    tcnt_next_ext = {1'b0, tcnt_q} + EXT_W'(1);
    if (phase_on_q) begin
      phase_end = (tcnt_next_ext >= {1'b0, on_len_i});
    end else begin
      phase_end = (tcnt_next_ext >= {1'b0, off_len_i});
    end
    win_o = arm_i && (!periodic_i || phase_on_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arm_i || !periodic_i) begin
      tcnt_q     <= '0;
      phase_on_q <= 1'b1;
    end else if (phase_end) begin
      tcnt_q     <= '0;
      phase_on_q <= !phase_on_q;
    end else begin
      tcnt_q <= tcnt_next_ext[TMR_W-1:0];
    end
  end

  // R7
  open_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_i) |-> win_o);

  // R6
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |-> !win_o);
endmodule

// File: rtl/burst_forcer.sv
module burst_forcer #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bl8_i,
  input  logic             beat_valid_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             level_i,
  output logic             busy_o,
  output logic [LANES-1:0] force_en_o,
  output logic [LANES-1:0] force_val_o
);
  import mei_pkg::*;

  burst_state_t      state_q;
  logic [BEAT_W-1:0] beat_idx_q;
  logic              bl8_q;
  logic [BEAT_W-1:0] last_idx;
  logic              beat_hot;

  always_comb begin
    last_idx = bl8_q ? BEAT_W'(MAX_BURST - 1) : BEAT_W'(MAX_BURST / 2 - 1);
    busy_o   = (state_q == BURST_CLAIMED);
    beat_hot = busy_o && beat_valid_i && !beat_idx_q[0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      force_en_o[g]  = beat_hot && mask_i[g];
      force_val_o[g] = beat_hot && mask_i[g] && level_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= BURST_IDLE;
      beat_idx_q <= '0;
      bl8_q      <= 1'b0;
    end else if (state_q == BURST_IDLE) begin
      if (start_i) begin
        state_q    <= BURST_CLAIMED;
        beat_idx_q <= '0;
        bl8_q      <= bl8_i;
      end
    end else if (beat_valid_i) begin
      if (beat_idx_q == last_idx) begin
        state_q    <= BURST_IDLE;
        beat_idx_q <= '0;
      end else begin
        beat_idx_q <= beat_idx_q + BEAT_W'(1);
      end
    end
  end

  // R4
  odd_beat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en_o != '0) |-> (beat_valid_i && busy_o));

  // R3
  val_in_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_val_o & ~force_en_o) == '0) && ((force_en_o & ~mask_i) == '0));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject #(
  parameter int ADDR_W = 16,
  parameter int CHIP_W = 2,
  parameter logic [CHIP_W-1:0] CHIP_ID = '0,
  parameter int LANES  = 8,
  parameter int TMR_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_write,
  input  logic [CHIP_W-1:0] cmd_chip,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_bl8,
  input  logic              beat_valid,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_mode,
  input  logic [LANES-1:0]  cfg_mask,
  input  logic              cfg_level,
  input  logic              cfg_arm,
  input  logic              cfg_periodic,
  input  logic [TMR_W-1:0]  cfg_on_len,
  input  logic [TMR_W-1:0]  cfg_off_len,
  input  logic              cnt_clr,
  output logic [LANES-1:0]  force_en,
  output logic [LANES-1:0]  force_val,
  output logic [CNT_W-1:0]  success_cnt
);
  logic hit;
  logic win;
  logic busy;
  logic accept;

  cmd_match #(.ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .CHIP_ID(CHIP_ID)) u_match (
    .cmd_valid_i   (cmd_valid),
    .cmd_is_write_i(cmd_is_write),
    .cmd_chip_i    (cmd_chip),
    .cmd_addr_i    (cmd_addr),
    .cfg_addr_i    (cfg_addr),
    .cfg_mode_i    (cfg_mode),
    .hit_o         (hit)
  );

  duty_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (cfg_arm),
    .periodic_i(cfg_periodic),
    .on_len_i  (cfg_on_len),
    .off_len_i (cfg_off_len),
    .win_o     (win)
  );

  assign accept = hit && win && !busy;

  burst_forcer #(.LANES(LANES)) u_forcer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .bl8_i       (cmd_bl8),
    .beat_valid_i(beat_valid),
    .mask_i      (cfg_mask),
    .level_i     (cfg_level),
    .busy_o      (busy),
    .force_en_o  (force_en),
    .force_val_o (force_val)
  );

  sat_counter #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(cnt_clr),
    .inc_i(accept),
    .cnt_o(success_cnt)
  );

  // R5
  count_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !cmd_valid) |=> $stable(success_cnt));

  // R6
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_arm && !cnt_clr) |=> $stable(success_cnt));
endmodule

// File: tb/tb_mem_err_inject.sv
module tb_mem_err_inject;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int CHIP_W = 2;
  localparam logic [CHIP_W-1:0] CHIP_ID = 2'd1;
  localparam int LANES  = 4;
  localparam int TMR_W  = 4;
  localparam int CNT_W  = 4;
  localparam logic [ADDR_W-1:0] MATCH_ADDR = 8'h5A;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_is_write = 1'b0;
  logic [CHIP_W-1:0] cmd_chip = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              cmd_bl8 = 1'b0;
  logic              beat_valid = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = MATCH_ADDR;
  logic [1:0]        cfg_mode = 2'd3;
  logic [LANES-1:0]  cfg_mask = 4'b0100;
  logic              cfg_level = 1'b1;
  logic              cfg_arm = 1'b1;
  logic              cfg_periodic = 1'b0;
  logic [TMR_W-1:0]  cfg_on_len = 4'd3;
  logic [TMR_W-1:0]  cfg_off_len = 4'd2;
  logic              cnt_clr = 1'b0;
  logic [LANES-1:0]  force_en;
  logic [LANES-1:0]  force_val;
  logic [CNT_W-1:0]  success_cnt;

  int checks = 0;
  int failures = 0;

  mem_err_inject #(
    .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .CHIP_ID(CHIP_ID),
    .LANES(LANES), .TMR_W(TMR_W), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
    .cmd_chip(cmd_chip), .cmd_addr(cmd_addr), .cmd_bl8(cmd_bl8),
    .beat_valid(beat_valid), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
    .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_arm(cfg_arm),
    .cfg_periodic(cfg_periodic), .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len),
    .cnt_clr(cnt_clr), .force_en(force_en), .force_val(force_val),
    .success_cnt(success_cnt)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; presents one command for one cycle.
  task automatic issue(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [CHIP_W-1:0] chip, input logic bl8);
    cmd_valid = 1'b1; cmd_is_write = wr; cmd_addr = a; cmd_chip = chip; cmd_bl8 = bl8;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Called at a falling edge; drives n beats and checks the force outputs.
  task automatic beats(input string tag, input int first, input int n, input int len,
                       input bit claimed);
    for (int b = first; b < first + n; b++) begin
      int exp_en;
      beat_valid = 1'b1;
      #1;
      exp_en = (claimed && b < len && (b % 2) == 0) ? int'(cfg_mask) : 0;
      check(tag, int'(force_en), exp_en);
      check(tag, int'(force_val), cfg_level ? exp_en : 0);
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  task automatic clear_cnt();
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 cnt", int'(success_cnt), 0);
    check("R11 force_en", int'(force_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    beats("R11 idle beats", 0, 2, 4, 1'b0);

    // R1 mode sweep
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        bit exp;
        cfg_mode = 2'(m);
        clear_cnt();
        issue(1'(w), MATCH_ADDR, CHIP_ID, 1'b0);
        exp = ((m >> w) & 1) == 1;
        check("R1 mode count", int'(success_cnt), int'(exp));
        beats("R1 mode force", 0, 4, 4, exp);
      end
    end
    cfg_mode = 2'd3;

    // R3 / R4 lane, level and burst length sweep
    for (int lane = 0; lane < LANES; lane++) begin
      for (int lv = 0; lv < 2; lv++) begin
        for (int bl = 0; bl < 2; bl++) begin
          cfg_mask = 4'(1 << lane);
          cfg_level = 1'(lv);
          issue(1'(lv), MATCH_ADDR, CHIP_ID, 1'(bl));
          beats("R3 R4 burst", 0, (bl ? 8 : 4) + 2, bl ? 8 : 4, 1'b1);
        end
      end
    end
    cfg_mask = 4'b1011;
    cfg_level = 1'b1;
    issue(1'b0, MATCH_ADDR, CHIP_ID, 1'b1);
    beats("R3 multi lane", 0, 8, 8, 1'b1);

    // R2 address and chip mismatch
    clear_cnt();
    for (int bit_i = 0; bit_i < ADDR_W; bit_i++) begin
      issue(1'b0, MATCH_ADDR ^ 8'(1 << bit_i), CHIP_ID, 1'b0);
      check("R2 addr miss count", int'(success_cnt), 0);
      beats("R2 addr miss force", 0, 2, 4, 1'b0);
    end
    for (int c = 0; c < 4; c++) begin
      if (c != int'(CHIP_ID)) begin
        issue(1'b1, MATCH_ADDR, 2'(c), 1'b0);
        check("R2 chip miss count", int'(success_cnt), 0);
        beats("R2 chip miss force", 0, 2, 4, 1'b0);
      end
    end
    issue(1'b1, MATCH_ADDR, CHIP_ID, 1'b0);
    check("R2 chip hit count", int'(success_cnt), 1);
    beats("R2 chip hit force", 0, 4, 4, 1'b1);

    // R6 disarmed
    clear_cnt();
    cfg_arm = 1'b0;
    issue(1'b0, MATCH_ADDR, CHIP_ID, 1'b1);
    check("R6 count", int'(success_cnt), 0);
    beats("R6 force", 0, 8, 8, 1'b0);
    cfg_arm = 1'b1;

    // R8 hit while busy
    clear_cnt();
    issue(1'b0, MATCH_ADDR, CHIP_ID, 1'b1);
    beats("R8 first part", 0, 3, 8, 1'b1);
    issue(1'b1, MATCH_ADDR, CHIP_ID, 1'b0);
    check("R8 busy count", int'(success_cnt), 1);
    beats("R8 rest", 3, 5, 8, 1'b1);
    beats("R8 after", 0, 2, 4, 1'b0);
    issue(1'b1, MATCH_ADDR, CHIP_ID, 1'b0);
    check("R8 next count", int'(success_cnt), 2);
    beats("R8 next force", 0, 4, 4, 1'b1);

    // R7 periodic window sweep
    for (int j = 0; j < 12; j++) begin
      bit exp;
      cfg_arm = 1'b0;
      clear_cnt();
      cfg_periodic = 1'b1;
      cfg_arm = 1'b1;
      repeat (j) @(negedge clk);
      issue(1'b0, MATCH_ADDR, CHIP_ID, 1'b0);
      exp = (j % (int'(cfg_on_len) + int'(cfg_off_len))) < int'(cfg_on_len);
      check("R7 window count", int'(success_cnt), int'(exp));
      beats("R7 window force", 0, 4, 4, exp);
    end
    cfg_periodic = 1'b0;

    // R5 / R9 counting and saturation
    clear_cnt();
    for (int k = 1; k <= 18; k++) begin
      issue(1'b1, MATCH_ADDR, CHIP_ID, 1'b0);
      check("R5 R9 count", int'(success_cnt), (k < 15) ? k : 15);
      beats("R5 force", 0, 4, 4, 1'b1);
    end

    // R10 clear beats a simultaneous increment, burst unaffected
    cnt_clr = 1'b1;
    issue(1'b0, MATCH_ADDR, CHIP_ID, 1'b0);
    cnt_clr = 1'b0;
    check("R10 clear count", int'(success_cnt), 0);
    beats("R10 force", 0, 4, 4, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule